// File: doc/BRIEF.md
# Miss Event Queue Between Two Cores

This block carries load-miss notifications from one processor core to a second core that runs a prefetching helper thread. On the producer side the retirement stage of the main core reports every committed load. The report carries the load's program counter, the data address it referenced, and two condition bits. One bit says the load missed in the cache. The other says it hit a line that the helper core had brought in. Either condition turns the committed load into an event. After a fixed transfer delay the event is placed in a bounded first-in first-out store. The producer is never held back. When the store is full, the arriving event is discarded and a discard counter advances.

On the consumer side the helper core sees the block as an input device at one reserved address. A read request to that address stays outstanding until an event can be supplied, and the helper thread stalls for that whole time. The event then comes back after the same fixed transfer delay, as a single-cycle response. Each response carries the program counter, the address, and a flag that tells a true miss apart from a hit on prefetched data. Requests to any other address are not answered.

Top module: `miss_event_queue`

## Requirements
- R1: After reset, `io_busy` and `io_rsp_valid` are low and `drop_count` is zero.
- R2: An event is created only from a cycle where `commit_valid` is high and at least one of `commit_missed` or `commit_tag_hit` is high. A commit with both flags low creates no event, and neither does a flag raised while `commit_valid` is low.
- R3: `io_rsp_prefetch_hit` is 1 when the event came from a tagged-line hit without a miss. It is 0 when the load missed, including when both flags were set.
- R4: The store holds at most `DEPTH` events (default 20), and its occupancy never exceeds `DEPTH`.
- R5: An event that arrives while the store is full, with no removal in the same cycle, is discarded and `drop_count` increases by one. There is no back-pressure toward the producer.
- R6: Events are returned in the order they were committed. This holds across wrap-around of the storage index.
- R7: An arrival and a removal in the same cycle on a full store both take effect. The arriving event is kept and `drop_count` does not change.
- R8: A request to `EVT_ADDR`, presented while `io_busy` is low and the store is non-empty, produces `io_rsp_valid` for exactly one cycle, `LAT` cycles after the request cycle. The response carries the oldest event.
- R9: A request on an empty store keeps `io_busy` high and produces no response until an event arrives. If a commit and the request happen in the same cycle on an empty, idle block, the response comes `2*LAT-1` cycles later.
- R10: A request to any address other than `EVT_ADDR` leaves `io_busy` low, produces no response and removes no event.
- R11: While `io_busy` is high, further requests are ignored, so at most one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commit_valid | input | 1 | A load commits this cycle |
| commit_missed | input | 1 | The committing load missed in the cache |
| commit_tag_hit | input | 1 | The committing load hit a line tagged by the helper core |
| commit_pc | input | 32 | Program counter of the committing load |
| commit_addr | input | 32 | Data address of the committing load |
| io_rd_req | input | 1 | Consumer read request, one-cycle pulse |
| io_rd_addr | input | IO_AW | Address of the consumer read |
| io_busy | output | 1 | A read is outstanding |
| io_rsp_valid | output | 1 | Response pulse |
| io_rsp_pc | output | 32 | Program counter of the returned event |
| io_rsp_addr | output | 32 | Data address of the returned event |
| io_rsp_prefetch_hit | output | 1 | 1 = hit on prefetched line, 0 = true miss |
| drop_count | output | CNT_W | Number of events discarded on a full store |

## Verification
The bench builds the block with `DEPTH=5` and `LAT=3`. Five is not a power of two, so a handful of events makes the storage index wrap through its explicit limit. It also fills the store and forces a discard within a few cycles. A latency of three is small enough that a commit can be timed to land on the same edge as a removal. That brings the full-store push-and-pop case within reach. It still leaves several register stages on each side, so the exact response cycles are measured against `LAT` and `2*LAT-1`.

// File: rtl/mevq_pkg.sv
package mevq_pkg;

    localparam int unsigned PC_W   = 32;
    localparam int unsigned ADDR_W = 32;

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [ADDR_W-1:0] addr;
        logic              pf_hit;
    } mev_t;

    localparam int unsigned MEV_W = $bits(mev_t);

    function automatic logic mev_fires(input logic missed, input logic tag_hit);
        return missed | tag_hit;
    endfunction

    function automatic mev_t mev_pack(input logic [PC_W-1:0] pc,
                                      input logic [ADDR_W-1:0] addr,
                                      input logic missed,
                                      input logic tag_hit);
        mev_t e;
        e.pc     = pc;
        e.addr   = addr;
        e.pf_hit = tag_hit & ~missed;
        return e;
    endfunction

    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/mevq_delay.sv
module mevq_delay
    import mevq_pkg::*;
#(
    parameter int unsigned STAGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  mev_t in_data,
    output logic out_valid,
    output mev_t out_data
);

    generate
        if (STAGES == 0) begin : g_pass
            assign out_valid = in_valid;
            assign out_data  = in_data;
        end else begin : g_pipe
            logic [STAGES-1:0] vld_q;
            mev_t              dat_q [STAGES];

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q <= '0;
                end else begin
                    vld_q[0] <= in_valid;
                    for (int i = 1; i < int'(STAGES); i++) begin
                        vld_q[i] <= vld_q[i-1];
                    end
                end
            end

            always_ff @(posedge clk) begin
                dat_q[0] <= in_data;
                for (int i = 1; i < int'(STAGES); i++) begin
                    dat_q[i] <= dat_q[i-1];
                end
            end

            assign out_valid = vld_q[STAGES-1];
            assign out_data  = dat_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/mevq_ring.sv
module mevq_ring
    import mevq_pkg::*;
#(
    parameter int unsigned DEPTH = 20,
    parameter int unsigned CNT_W = 16,
    localparam int unsigned PW   = idx_width(DEPTH),
    localparam int unsigned QW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_valid,
    input  mev_t             push_data,
    input  logic             pop,
    output mev_t             head,
    output logic [QW-1:0]    count,
    output logic [CNT_W-1:0] drops
);

    mev_t             slots [DEPTH];
    logic [PW-1:0]    wr_q, rd_q;
    logic [QW-1:0]    cnt_q;
    logic [CNT_W-1:0] drop_q;
    logic             full, empty, do_pop, accept, discard;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (cnt_q == QW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_pop  = pop & ~empty;
    assign accept  = push_valid & (~full | do_pop);
    assign discard = push_valid & ~accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            rd_q   <= '0;
            cnt_q  <= '0;
            drop_q <= '0;
        end else begin
            if (accept) wr_q <= step(wr_q);
            if (do_pop) rd_q <= step(rd_q);
            case ({accept, do_pop})
                2'b10:   cnt_q <= cnt_q + QW'(1);
                2'b01:   cnt_q <= cnt_q - QW'(1);
                default: cnt_q <= cnt_q;
            endcase
            if (discard && drop_q != '1) drop_q <= drop_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (accept) slots[wr_q] <= push_data;
    end

    assign head  = slots[rd_q];
    assign count = cnt_q;
    assign drops = drop_q;

endmodule

// File: rtl/mevq_rdport.sv
module mevq_rdport
    import mevq_pkg::*;
#(
    parameter int unsigned          IO_AW    = 16,
    parameter logic [IO_AW-1:0]     EVT_ADDR = '1,
    parameter int unsigned          LAT      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_req,
    input  logic [IO_AW-1:0] rd_addr,
    input  logic             q_empty,
    input  mev_t             q_head,
    output logic             q_pop,
    output logic             busy,
    output logic             rsp_valid,
    output mev_t             rsp_data
);

    logic pend_q, taken_q, accept;

    assign accept = rd_req & ~pend_q & (rd_addr == EVT_ADDR);
    assign q_pop  = pend_q & ~taken_q & ~q_empty;

    mevq_delay #(.STAGES(LAT - 1)) u_rsp_dly (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (q_pop),
        .in_data   (q_head),
        .out_valid (rsp_valid),
        .out_data  (rsp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            taken_q <= 1'b0;
        end else if (rsp_valid) begin
            pend_q  <= 1'b0;
            taken_q <= 1'b0;
        end else begin
            if (accept) pend_q  <= 1'b1;
            if (q_pop)  taken_q <= 1'b1;
        end
    end

    assign busy = pend_q;

endmodule

// File: rtl/miss_event_queue.sv
module miss_event_queue
    import mevq_pkg::*;
#(
    parameter int unsigned      DEPTH    = 20,
    parameter int unsigned      LAT      = 5,
    parameter int unsigned      IO_AW    = 16,
    parameter logic [IO_AW-1:0] EVT_ADDR = 16'hFF00,
    parameter int unsigned      CNT_W    = 16,
    localparam int unsigned     QW       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_valid,
    input  logic              commit_missed,
    input  logic              commit_tag_hit,
    input  logic [PC_W-1:0]   commit_pc,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic              io_rd_req,
    input  logic [IO_AW-1:0]  io_rd_addr,
    output logic              io_busy,
    output logic              io_rsp_valid,
    output logic [PC_W-1:0]   io_rsp_pc,
    output logic [ADDR_W-1:0] io_rsp_addr,
    output logic              io_rsp_prefetch_hit,
    output logic [CNT_W-1:0]  drop_count
);

    logic          trig, arr_valid, q_pop;
    mev_t          trig_data, arr_data, q_head, rsp;
    logic [QW-1:0] q_count;

    assign trig      = commit_valid & mev_fires(commit_missed, commit_tag_hit);
    assign trig_data = mev_pack(commit_pc, commit_addr, commit_missed, commit_tag_hit);

    mevq_delay #(.STAGES(LAT - 1)) u_push_dly (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (trig),
        .in_data   (trig_data),
        .out_valid (arr_valid),
        .out_data  (arr_data)
    );

    mevq_ring #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ring (
        .clk        (clk),
        .rst        (rst),
        .push_valid (arr_valid),
        .push_data  (arr_data),
        .pop        (q_pop),
        .head       (q_head),
        .count      (q_count),
        .drops      (drop_count)
    );

    mevq_rdport #(.IO_AW(IO_AW), .EVT_ADDR(EVT_ADDR), .LAT(LAT)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (io_rd_req),
        .rd_addr   (io_rd_addr),
        .q_empty   (q_count == '0),
        .q_head    (q_head),
        .q_pop     (q_pop),
        .busy      (io_busy),
        .rsp_valid (io_rsp_valid),
        .rsp_data  (rsp)
    );

    assign io_rsp_pc           = rsp.pc;
    assign io_rsp_addr         = rsp.addr;
    assign io_rsp_prefetch_hit = rsp.pf_hit;

endmodule

// File: rtl/mevq_checker.sv
module mevq_checker #(
    parameter int unsigned      DEPTH    = 20,
    parameter int unsigned      IO_AW    = 16,
    parameter logic [IO_AW-1:0] EVT_ADDR = 16'hFF00,
    parameter int unsigned      CNT_W    = 16,
    parameter int unsigned      QW       = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [QW-1:0]    q_count,
    input logic             q_pop,
    input logic [CNT_W-1:0] drop_count,
    input logic             io_busy,
    input logic             io_rsp_valid,
    input logic             io_rd_req,
    input logic [IO_AW-1:0] io_rd_addr
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        q_count <= QW'(DEPTH)); // R4

    AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        (drop_count != $past(drop_count)) |-> ($past(q_count) == QW'(DEPTH))); // R5

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        q_pop |-> (q_count != '0)); // R6

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        io_rsp_valid |=> !io_rsp_valid); // R8

    AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        io_rsp_valid |-> io_busy); // R11

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (io_busy && !io_rsp_valid) |=> io_busy); // R9

    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!io_busy && io_rd_req && io_rd_addr != EVT_ADDR) |=> !io_busy); // R10

endmodule

bind miss_event_queue mevq_checker #(
    .DEPTH(DEPTH), .IO_AW(IO_AW), .EVT_ADDR(EVT_ADDR), .CNT_W(CNT_W), .QW(QW)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .q_count      (q_count),
    .q_pop        (q_pop),
    .drop_count   (drop_count),
    .io_busy      (io_busy),
    .io_rsp_valid (io_rsp_valid),
    .io_rd_req    (io_rd_req),
    .io_rd_addr   (io_rd_addr)
);

// File: tb/miss_event_queue_tb.sv
module miss_event_queue_tb;

    localparam int unsigned      DEPTH = 5;
    localparam int unsigned      LAT   = 3;
    localparam int unsigned      IO_AW = 16;
    localparam logic [IO_AW-1:0] EVTA  = 16'hFE00;
    localparam int unsigned      CNT_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              commit_valid, commit_missed, commit_tag_hit;
    logic [31:0]       commit_pc, commit_addr;
    logic              io_rd_req;
    logic [IO_AW-1:0]  io_rd_addr;
    logic              io_busy, io_rsp_valid, io_rsp_prefetch_hit;
    logic [31:0]       io_rsp_pc, io_rsp_addr;
    logic [CNT_W-1:0]  drop_count;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    miss_event_queue #(
        .DEPTH(DEPTH), .LAT(LAT), .IO_AW(IO_AW), .EVT_ADDR(EVTA), .CNT_W(CNT_W)
    ) u_dut (
        .clk(clk), .rst(rst),
        .commit_valid(commit_valid), .commit_missed(commit_missed),
        .commit_tag_hit(commit_tag_hit), .commit_pc(commit_pc),
        .commit_addr(commit_addr), .io_rd_req(io_rd_req), .io_rd_addr(io_rd_addr),
        .io_busy(io_busy), .io_rsp_valid(io_rsp_valid), .io_rsp_pc(io_rsp_pc),
        .io_rsp_addr(io_rsp_addr), .io_rsp_prefetch_hit(io_rsp_prefetch_hit),
        .drop_count(drop_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic logic [31:0] pc_of(input int i);
        return 32'h0040_1000 + 32'(i * 4);
    endfunction

    function automatic logic [31:0] ad_of(input int i);
        return 32'h8000_0000 + 32'(i * 64);
    endfunction

    task automatic drive_commit(input bit v, input int i, input bit miss, input bit tag);
        commit_valid   = v;
        commit_missed  = miss;
        commit_tag_hit = tag;
        commit_pc      = pc_of(i);
        commit_addr    = ad_of(i);
    endtask

    task automatic commit(input int i, input bit miss, input bit tag);
        drive_commit(1'b1, i, miss, tag);
        cyc(1);
        drive_commit(1'b0, 0, 1'b0, 1'b0);
    endtask

    // Waits for the response; n is the cycle offset from the request cycle.
    task automatic wait_rsp(output int n);
        n = 1;
        while (!io_rsp_valid && n < 400) begin
            cyc(1);
            n++;
        end
    endtask

    task automatic read_expect(input string req, input int i, input bit pf, input int exp_lat);
        int n;
        io_rd_req  = 1'b1;
        io_rd_addr = EVTA;
        cyc(1);
        io_rd_req  = 1'b0;
        wait_rsp(n);
        check(io_rsp_valid && io_rsp_pc == pc_of(i) && io_rsp_addr == ad_of(i)
              && io_rsp_prefetch_hit == pf, req, "response event",
              {io_rsp_valid, io_rsp_pc, io_rsp_addr, io_rsp_prefetch_hit},
              {1'b1, pc_of(i), ad_of(i), pf});
        if (exp_lat > 0)
            check(n == exp_lat, req, "response latency", 128'(n), 128'(exp_lat));
        cyc(1);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive_commit(1'b0, 0, 1'b0, 1'b0);
        io_rd_req  = 1'b0;
        io_rd_addr = '0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic t_reset();
        do_reset();
        check(!io_busy && !io_rsp_valid && drop_count == 0, "R1", "reset outputs",
              {io_busy, io_rsp_valid, drop_count}, 128'd0);
    endtask

    task automatic t_latency();
        do_reset();
        commit(1, 1'b1, 1'b0);
        cyc(LAT);
        read_expect("R8", 1, 1'b0, LAT);
        // R9: commit and read in the same cycle on an empty, idle block
        drive_commit(1'b1, 2, 1'b1, 1'b0);
        io_rd_req  = 1'b1;
        io_rd_addr = EVTA;
        cyc(1);
        drive_commit(1'b0, 0, 1'b0, 1'b0);
        io_rd_req = 1'b0;
        begin
            int n;
            wait_rsp(n);
            check(io_rsp_valid && io_rsp_pc == pc_of(2), "R9", "same-cycle event",
                  io_rsp_pc, pc_of(2));
            check(n == 2 * LAT - 1, "R9", "same-cycle latency", 128'(n), 128'(2 * LAT - 1));
        end
        cyc(1);
    endtask

    task automatic t_kind_filter();
        bit seen;
        do_reset();
        commit(3, 1'b0, 1'b0);        // R2: valid but no condition
        drive_commit(1'b0, 4, 1'b1, 1'b1);
        cyc(1);                       // R2: conditions without valid
        commit(5, 1'b0, 1'b1);
        commit(6, 1'b1, 1'b1);
        cyc(LAT);
        read_expect("R3", 5, 1'b1, LAT);
        read_expect("R3", 6, 1'b0, LAT);
        // R2/R9: store must be empty now; read stalls
        io_rd_req  = 1'b1;
        io_rd_addr = EVTA;
        cyc(1);
        io_rd_req = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (io_rsp_valid || !io_busy) seen = 1'b1;
            cyc(1);
        end
        check(!seen, "R2", "no phantom event, read stalls", 128'(seen), 128'd0);
        check(io_busy, "R9", "busy while waiting", 128'(io_busy), 128'd1);
        commit(7, 1'b1, 1'b0);
        begin
            int n;
            wait_rsp(n);
            check(io_rsp_valid && io_rsp_pc == pc_of(7) && !io_rsp_prefetch_hit, "R9",
                  "stalled read completes", {io_rsp_valid, io_rsp_pc}, {1'b1, pc_of(7)});
        end
        cyc(1);
        check(!io_busy, "R9", "busy released", 128'(io_busy), 128'd0);
    endtask

    task automatic t_ignore();
        bit seen;
        do_reset();
        commit(8, 1'b1, 1'b0);
        cyc(LAT);
        io_rd_req  = 1'b1;
        io_rd_addr = EVTA ^ 16'h0004;
        cyc(1);
        io_rd_req = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < int'(LAT) + 3; k++) begin
            if (io_rsp_valid || io_busy) seen = 1'b1;
            cyc(1);
        end
        check(!seen, "R10", "foreign read ignored", 128'(seen), 128'd0);
        read_expect("R10", 8, 1'b0, LAT);
    endtask

    task automatic t_busy_block();
        int n;
        do_reset();
        commit(9, 1'b1, 1'b0);
        commit(10, 1'b1, 1'b0);
        cyc(LAT);
        io_rd_req  = 1'b1;
        io_rd_addr = EVTA;
        cyc(1);
        cyc(1);                       // second request held while busy
        io_rd_req = 1'b0;
        wait_rsp(n);
        check(io_rsp_pc == pc_of(9), "R11", "first read", io_rsp_pc, pc_of(9));
        cyc(1);
        n = 0;
        for (int k = 0; k < 2 * int'(LAT) + 2; k++) begin
            if (io_rsp_valid) n++;
            cyc(1);
        end
        check(n == 0, "R11", "extra request ignored", 128'(n), 128'd0);
        read_expect("R11", 10, 1'b0, LAT);
    endtask

    task automatic t_full_order();
        do_reset();
        for (int i = 11; i <= 16; i++) commit(i, 1'b1, 1'b0);
        cyc(LAT);
        check(drop_count == 1, "R5", "drop on full", 128'(drop_count), 128'd1);
        // R7: arrival of 17 coincides with removal of 11
        commit(17, 1'b0, 1'b1);
        cyc(LAT - 3);
        read_expect("R7", 11, 1'b0, LAT);
        check(drop_count == 1, "R7", "no drop on push+pop", 128'(drop_count), 128'd1);
        for (int i = 12; i <= 15; i++) read_expect("R6", i, 1'b0, LAT);
        read_expect("R4", 17, 1'b1, LAT);
        check(drop_count == 1, "R5", "drop count stable", 128'(drop_count), 128'd1);
    endtask

    initial begin
        int wd = 0;
        while (!done) begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", wd);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_kind_filter();
        t_ignore();
        t_busy_block();
        t_full_order();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule